// File: doc/BRIEF.md
# UART Receive Byte Queue with Character Timeout

This block holds the bytes that a serial deserialiser delivers to the host side of a 16550-style UART. In queued mode it stores up to sixteen bytes in arrival order. It raises a data-available interrupt once the stored count reaches a trigger level that two control bits select. It raises a timeout interrupt when bytes sit unread for four character times. In single-byte mode it behaves as one holding register, which accepts a new byte only after the host has read the previous one.

The deserialiser presents each byte with a valid strobe, plus a flag that marks the byte as a line break. The host sees the oldest byte on the read-data port and removes it with a read strobe. A reset strobe empties the queue and clears the pending conditions. A one-cycle tick per character time drives the timeout measurement.

Top module: `uart_rx_fifo`

## Requirements
- R1: In queued mode `rda_irq` is high exactly while the stored count is at or above the level chosen by `trig_sel`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R2: The queue holds 16 bytes. A byte that arrives while the queue is full is dropped and sets `overrun`. `overrun` stays set until a queue reset.
- R3: Bytes leave in arrival order. `rd_data` shows the oldest stored byte, `rd_stb` removes it, and a read of an empty queue changes nothing.
- R4: In queued mode `timeout_irq` rises on the clock edge of the fourth `char_tick` after the latest restart, provided the queue still holds data.
- R5: Every accepted byte restarts the timeout count.
- R6: A read clears a pending `timeout_irq`. A read that leaves data behind restarts the timeout count.
- R7: `data_ready` is high while any byte is stored. A read that empties the store clears both `data_ready` and `break_flag`.
- R8: `fifo_rst` empties the store and clears `timeout_irq`, `overrun`, `break_flag` and the timeout count. A byte that arrives in the same cycle is discarded.
- R9: A byte flagged by `rx_break` is stored as 8'h00 and sets `break_flag` and `data_ready`.
- R10: With `fifo_en` low the store holds one byte. A byte that arrives while `data_ready` is high is dropped and sets `overrun`. `rda_irq` follows `data_ready`, and `timeout_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-byte queued mode, 0 = single holding byte |
| trig_sel | input | 2 | Trigger level select |
| rx_valid | input | 1 | Byte strobe from the deserialiser |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Marks the strobed byte as a line break |
| rd_stb | input | 1 | Host read: removes the oldest byte |
| fifo_rst | input | 1 | Empties the store and clears pending conditions |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_data | output | 8 | Oldest stored byte (0 when empty) |
| data_ready | output | 1 | Store holds at least one byte |
| break_flag | output | 1 | A stored break has not yet been drained |
| overrun | output | 1 | A byte was dropped because the store was full |
| rda_irq | output | 1 | Count at or above the trigger level |
| timeout_irq | output | 1 | Data left unread for four character times |

## Verification
For every trigger encoding, the bench fills the queue one byte at a time from empty to full. A level decoded off by one, or with two encodings swapped, shows up as the interrupt changing one byte early or late. The bench then pushes one more byte, which must be dropped with `overrun` set. A design that wraps its write pointer instead would overwrite the oldest byte, and the ordered drain would expose it. The timeout sequence counts ticks exactly (three quiet, the fourth firing) and restarts the count by a push and by a partial read. A timer that misses one of the restarts, or that fires on an empty store, therefore shows up. The bench also covers a queue reset in the same cycle as an arriving byte, a break byte held behind later data, and the single-byte mode that must refuse a second byte.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE      = 2'b00,
      TRIG_FOUR     = 2'b01,
      TRIG_EIGHT    = 2'b10,
      TRIG_FOURTEEN = 2'b11
   } trig_sel_e;

   localparam int unsigned MAX_TRIG_LEVEL = 14;

   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (trig_sel_e'(sel))
         TRIG_ONE:   return 1;
         TRIG_FOUR:  return 4;
         TRIG_EIGHT: return 8;
         default:    return MAX_TRIG_LEVEL;
      endcase
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count
);
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          POW2 = ((1 << AW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_free
         always_comb begin
            wr_nxt = wr_ptr + 1'b1;
            rd_nxt = rd_ptr + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rd_ptr];

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (count < CW'(DEPTH)));
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
   parameter int unsigned CHARS = 4,
   localparam int unsigned TW   = $clog2(CHARS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic restart,
   input  logic holding,
   input  logic tick,
   input  logic ack,
   output logic irq
);
   logic [TW-1:0] cnt;

   generate
      if (CHARS < 1) begin : g_bad_chars
         $error("rxf_timer: CHARS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (clear || restart || !holding) cnt <= '0;
      else if (tick && cnt != TW'(CHARS))  cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               irq <= 1'b0;
      else if (clear || ack)    irq <= 1'b0;
      else if (holding && tick && !restart && cnt == TW'(CHARS - 1))
                                irq <= 1'b1;
   end

   a_r4_fire_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(holding));
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq);
   a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !irq) |=> !irq);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rxf_pkg::*;
#(
   parameter int unsigned DEPTH         = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned TIMEOUT_CHARS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic [1:0]        trig_sel,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_break,
   input  logic              rd_stb,
   input  logic              fifo_rst,
   input  logic              char_tick,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_ready,
   output logic              break_flag,
   output logic              overrun,
   output logic              rda_irq,
   output logic              timeout_irq
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < MAX_TRIG_LEVEL) begin : g_bad_depth
         $error("uart_rx_fifo: DEPTH must reach the highest trigger level");
      end
   endgenerate

   logic [CW-1:0]     count, cap;
   logic [DATA_W-1:0] head, wbyte;
   logic              has_data, full, push, pop, drop, restart;

   assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
   assign has_data = (count != '0);
   assign full     = (count >= cap);
   assign push     = rx_valid && !full && !fifo_rst;
   assign drop     = rx_valid && full && !fifo_rst;
   assign pop      = rd_stb && has_data && !fifo_rst;
   assign wbyte    = rx_break ? '0 : rx_data;
   assign restart  = push || (pop && (count > CW'(1)));

   rxf_store #(.DEPTH(DEPTH), .W(DATA_W)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (fifo_rst),
      .push  (push),
      .pop   (pop),
      .wdata (wbyte),
      .rdata (head),
      .count (count)
   );

   rxf_timer #(.CHARS(TIMEOUT_CHARS)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (fifo_rst || !fifo_en),
      .restart (restart),
      .holding (fifo_en && has_data),
      .tick    (char_tick),
      .ack     (pop),
      .irq     (timeout_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        overrun <= 1'b0;
      else if (fifo_rst) overrun <= 1'b0;
      else if (drop)     overrun <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        break_flag <= 1'b0;
      else if (fifo_rst)                 break_flag <= 1'b0;
      else if (push && rx_break)         break_flag <= 1'b1;
      else if (pop && count == CW'(1))   break_flag <= 1'b0;
   end

   assign data_ready = has_data;
   assign rd_data    = has_data ? head : '0;
   assign rda_irq    = fifo_en ? (count >= CW'(trig_level(trig_sel))) : has_data;

   a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |=> (!data_ready && !timeout_irq && !overrun && !break_flag));
   a_r2_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> overrun);
   a_r7_last_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == CW'(1) && !push) |=> (!data_ready && !break_flag));
   a_r9_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (push && rx_break) |=> (break_flag && data_ready));
   a_r10_single_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && has_data && rx_valid && !fifo_rst) |=> overrun);
   a_r10_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> !timeout_irq);
   a_r1_top_level: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && count >= CW'(MAX_TRIG_LEVEL)) |-> rda_irq);

endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1;
   logic [1:0] trig_sel = 2'b00;
   logic       rx_valid = 1'b0, rx_break = 1'b0, rd_stb = 1'b0;
   logic       fifo_rst = 1'b0, char_tick = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic [7:0] rd_data;
   logic       data_ready, break_flag, overrun, rda_irq, timeout_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   uart_rx_fifo i_uart_rx_fifo (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
      .rd_stb(rd_stb), .fifo_rst(fifo_rst), .char_tick(char_tick),
      .rd_data(rd_data), .data_ready(data_ready), .break_flag(break_flag),
      .overrun(overrun), .rda_irq(rda_irq), .timeout_irq(timeout_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic v, input logic [7:0] d, input logic b,
                      input logic rd, input logic rs, input logic tk);
      rx_valid = v; rx_data = d; rx_break = b;
      rd_stb = rd; fifo_rst = rs; char_tick = tk;
      @(posedge clk);
      #(CLK_P/4);
      rx_valid = 1'b0; rx_break = 1'b0; rd_stb = 1'b0;
      fifo_rst = 1'b0; char_tick = 1'b0;
   endtask

   function automatic int lvl_of(input int t);
      case (t)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic logic [7:0] pat(input int t, input int n);
      return 8'((t * 16 + n) ^ 8'h5A);
   endfunction

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 3);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #(CLK_P/4);
      chk("R7 reset data_ready", data_ready, 0);
      chk("R1 reset rda_irq", rda_irq, 0);
      chk("R4 reset timeout_irq", timeout_irq, 0);
      chk("R2 reset overrun", overrun, 0);

      // R1 R2 R3 sweep over every trigger encoding
      for (int t = 0; t < 4; t++) begin
         trig_sel = 2'(t);
         cyc(0, 0, 0, 0, 1, 0);
         for (int n = 1; n <= 16; n++) begin
            cyc(1, pat(t, n), 0, 0, 0, 0);
            chk("R1 trigger level", rda_irq, (n >= lvl_of(t)) ? 1 : 0);
            chk("R7 data_ready while filling", data_ready, 1);
         end
         chk("R2 no overrun at exactly full", overrun, 0);
         cyc(1, 8'hEE, 0, 0, 0, 0);
         chk("R2 overrun on full", overrun, 1);
         for (int n = 1; n <= 16; n++) begin
            chk("R3 order", rd_data, pat(t, n));
            cyc(0, 0, 0, 1, 0, 0);
         end
         chk("R7 drained data_ready", data_ready, 0);
         chk("R1 drained rda_irq", rda_irq, 0);
         cyc(0, 0, 0, 1, 0, 0);
         chk("R3 empty read no effect", data_ready, 0);
         chk("R2 overrun sticky", overrun, 1);
         cyc(0, 0, 0, 0, 1, 0);
         chk("R8 reset clears overrun", overrun, 0);
      end

      // R4 R5 R6 timeout
      trig_sel = 2'b11;
      cyc(1, 8'h10, 0, 0, 0, 0);
      cyc(1, 8'h11, 0, 0, 0, 0);
      for (int k = 1; k <= 3; k++) begin
         cyc(0, 0, 0, 0, 0, 1);
         chk("R4 quiet before fourth tick", timeout_irq, 0);
      end
      cyc(0, 0, 0, 0, 0, 1);
      chk("R4 fires on fourth tick", timeout_irq, 1);
      cyc(0, 0, 0, 1, 0, 0);
      chk("R6 read clears timeout", timeout_irq, 0);
      for (int k = 1; k <= 3; k++) cyc(0, 0, 0, 0, 0, 1);
      chk("R6 partial read restarted count", timeout_irq, 0);
      cyc(1, 8'h12, 0, 0, 0, 0);
      for (int k = 1; k <= 3; k++) begin
         cyc(0, 0, 0, 0, 0, 1);
         chk("R5 push restarted count", timeout_irq, 0);
      end
      cyc(0, 0, 0, 0, 0, 1);
      chk("R5 fires four ticks after push", timeout_irq, 1);
      chk("R3 head after one read", rd_data, 8'h11);
      cyc(0, 0, 0, 1, 0, 0);
      cyc(0, 0, 0, 1, 0, 0);
      chk("R7 empty after reads", data_ready, 0);
      for (int k = 1; k <= 6; k++) cyc(0, 0, 0, 0, 0, 1);
      chk("R4 no timeout when empty", timeout_irq, 0);

      // R8 reset beats a same-cycle byte, and clears a pending timeout
      cyc(1, 8'h21, 0, 0, 0, 0);
      for (int k = 1; k <= 4; k++) cyc(0, 0, 0, 0, 0, 1);
      chk("R4 pending before reset", timeout_irq, 1);
      cyc(1, 8'h22, 0, 0, 1, 0);
      chk("R8 reset discards byte", data_ready, 0);
      chk("R8 reset clears timeout", timeout_irq, 0);

      // R9 break handling
      cyc(1, 8'hA7, 1, 0, 0, 0);
      chk("R9 break data zero", rd_data, 0);
      chk("R9 break flag", break_flag, 1);
      chk("R9 break data_ready", data_ready, 1);
      cyc(1, 8'h33, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0);
      chk("R7 break held while data remains", break_flag, 1);
      chk("R3 next byte after break", rd_data, 8'h33);
      cyc(0, 0, 0, 1, 0, 0);
      chk("R7 break cleared on empty", break_flag, 0);

      // R10 single holding byte
      fifo_en = 1'b0;
      cyc(0, 0, 0, 0, 1, 0);
      cyc(1, 8'h44, 0, 0, 0, 0);
      chk("R10 data_ready", data_ready, 1);
      chk("R10 rda follows data_ready", rda_irq, 1);
      cyc(1, 8'h55, 0, 0, 0, 0);
      chk("R10 second byte overrun", overrun, 1);
      chk("R10 first byte kept", rd_data, 8'h44);
      for (int k = 1; k <= 8; k++) cyc(0, 0, 0, 0, 0, 1);
      chk("R10 no timeout", timeout_irq, 0);
      cyc(0, 0, 0, 1, 0, 0);
      chk("R10 read clears data_ready", data_ready, 0);
      chk("R10 rda low when empty", rda_irq, 0);
      cyc(1, 8'h66, 0, 0, 0, 0);
      chk("R10 accepts after read", rd_data, 8'h66);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule